// File: doc/BRIEF.md
# Prescaler-Extended Interval Timer with Match

This block is one timer channel. A 16-bit counter field and an 8-bit prescaler field together hold a 24-bit count that advances once per clock. The channel runs in one-shot or periodic mode and counts up or down. Software writes an interval limit, can preload the live count, can arm a 24-bit match point, and can ask for the count to be captured at every periodic time-out. Two interrupt sources, time-out and match, have raw status, a mask, masked status and a write-one-to-clear register. All of these sit behind a flat register port.

The prescaler's role depends on the count direction. When counting down it is a true prescaler and holds the low 8 bits of the count. When counting up it extends the counter and holds the high 8 bits. The counter and prescaler readback registers, the match pair and the snapshot all use the same split. The interval limit and the value register are plain 24-bit counts.

Register map (word address on `addr_i`):
- 0 control: bit0 run enable, bit1 periodic (0 selects one-shot), bit2 count up, bit3 snapshot enable
- 1 interval limit
- 2 match, counter part
- 3 match, prescaler part
- 4 live 24-bit value
- 5 counter-field readback
- 6 prescaler-field readback
- 7 interrupt mask
- 8 raw status
- 9 masked status
- 10 clear (write only, reads zero)

In the mask and status registers, bit0 is time-out and bit1 is match.

Top module: `pxt_timer`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: When counting down, the 24-bit count decreases by one per enabled cycle. The counter readback shows count bits 23:8 and the prescaler readback shows bits 7:0.
- R3: When counting up, the 24-bit count increases by one per enabled cycle. The counter readback shows count bits 15:0 and the prescaler readback shows bits 23:16.
- R4: A write to address 4 sets the live count to the written 24-bit value at that clock edge. This takes priority over counting.
- R5: A time-out happens on an enabled cycle where the count is zero (down) or equals the interval limit (up). It sets raw status bit0. In periodic mode the next count is the interval limit (down) or zero (up).
- R6: In one-shot mode a time-out clears control bit0 and the count holds its value. A control write in the same cycle takes priority.
- R7: The match point is {match, prescale-match} when counting down and {prescale-match, match} when counting up. Raw status bit1 is set once, on the first enabled cycle the count equals the match point.
- R8: With periodic mode and snapshot enabled, each time-out captures the counter and prescaler fields into readbacks 5 and 6. Address 4 keeps showing the live count.
- R9: In one-shot mode, or with snapshot disabled, readbacks 5 and 6 follow the live count.
- R10: Masked status equals raw status AND mask, and `irq_o` is the OR of the masked bits. Writing the mask never changes raw status.
- R11: Writing ones to address 10 clears those raw status bits. An event in the same cycle keeps its bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 24 | Write data |
| rdata_o | output | 24 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Interrupt request, OR of masked status |

## Verification
The step and reload assertions assume the count never goes past the interval limit while counting up. If software preloads a value above the limit, the count runs around the full 24-bit range before the next time-out. The stimulus therefore always preloads an up-count at or below the limit. It also changes direction only while the channel is stopped, so the field split never flips under a running count. Clear writes are held across match and time-out events on purpose, so that set-wins collisions occur, and a reference model checks the result every cycle.

// File: rtl/pxt_pkg.sv
package pxt_pkg;
  localparam int unsigned AW = 4;
  localparam logic [AW-1:0] A_CTRL  = 4'd0;
  localparam logic [AW-1:0] A_LIMIT = 4'd1;
  localparam logic [AW-1:0] A_MHI   = 4'd2;
  localparam logic [AW-1:0] A_MPRE  = 4'd3;
  localparam logic [AW-1:0] A_VAL   = 4'd4;
  localparam logic [AW-1:0] A_TCNT  = 4'd5;
  localparam logic [AW-1:0] A_TPRE  = 4'd6;
  localparam logic [AW-1:0] A_MASK  = 4'd7;
  localparam logic [AW-1:0] A_RAW   = 4'd8;
  localparam logic [AW-1:0] A_MSK   = 4'd9;
  localparam logic [AW-1:0] A_CLR   = 4'd10;
  localparam int unsigned NIRQ = 2;  // bit0 time-out, bit1 match
endpackage

// File: rtl/pxt_core.sv
module pxt_core #(
  parameter int unsigned TW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          up_i,
  input  logic          periodic_i,
  input  logic [TW-1:0] limit_i,
  input  logic          set_i,
  input  logic [TW-1:0] set_val_i,
  output logic [TW-1:0] cnt_o,
  output logic          tmo_o
);
  logic [TW-1:0] cnt_q;

  assign tmo_o = run_i && (up_i ? (cnt_q == limit_i) : (cnt_q == '0));
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (set_i)       cnt_q <= set_val_i;
    else if (run_i) begin
      if (tmo_o) begin
        if (periodic_i) cnt_q <= up_i ? '0 : limit_i;
      end else begin
        cnt_q <= up_i ? cnt_q + TW'(1) : cnt_q - TW'(1);
      end
    end
  end

  a_r2_down_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !up_i && !set_i && cnt_q != '0 |=> cnt_q == $past(cnt_q) - TW'(1));
  a_r3_up_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && up_i && !set_i && cnt_q != limit_i |=> cnt_q == $past(cnt_q) + TW'(1));
  a_r5_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_o && periodic_i && !set_i |=> cnt_q == ($past(up_i) ? '0 : $past(limit_i)));
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_o && !periodic_i && !set_i |=> $stable(cnt_q));
endmodule

// File: rtl/pxt_match.sv
module pxt_match #(
  parameter int unsigned CW = 16,
  parameter int unsigned PW = 8,
  localparam int unsigned TW = CW + PW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          up_i,
  input  logic [TW-1:0] cnt_i,
  input  logic [CW-1:0] mhi_i,
  input  logic [PW-1:0] mpre_i,
  output logic          hit_o
);
  logic [TW-1:0] point;
  logic          eq, eq_q;

  // prescaler part is low bits counting down, high bits counting up
  assign point = up_i ? {mpre_i, mhi_i} : {mhi_i, mpre_i};
  assign eq    = run_i && (cnt_i == point);
  assign hit_o = eq && !eq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eq_q <= 1'b0;
    else         eq_q <= eq;
  end

  a_r7_single_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> !hit_o);
endmodule

// File: rtl/pxt_irq.sv
module pxt_irq #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] ev_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] raw_o,
  output logic [N-1:0] msk_o,
  output logic         irq_o
);
  logic [N-1:0] raw_q;

  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) raw_q[i] <= 1'b0;
      else         raw_q[i] <= ev_i[i] | (raw_q[i] & ~clr_i[i]);
    end

    a_r11_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_i[i] |=> raw_q[i]);
    a_r11_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[i] && !ev_i[i] |=> !raw_q[i]);
    a_r10_raw_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ev_i[i] && !clr_i[i] |=> raw_q[i] == $past(raw_q[i]));
  end

  assign raw_o = raw_q;
  assign msk_o = raw_q & mask_i;
  assign irq_o = |msk_o;
endmodule

// File: rtl/pxt_timer.sv
module pxt_timer #(
  parameter int unsigned CW = 16,
  parameter int unsigned PW = 8,
  localparam int unsigned TW = CW + PW
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [pxt_pkg::AW-1:0] addr_i,
  input  logic [TW-1:0]          wdata_i,
  output logic [TW-1:0]          rdata_o,
  output logic                   irq_o
);
  import pxt_pkg::*;

  logic en_q, per_q, up_q, snap_q;
  logic [TW-1:0]   limit_q;
  logic [CW-1:0]   mhi_q, snc_q;
  logic [PW-1:0]   mpre_q, snp_q;
  logic [NIRQ-1:0] mask_q, raw, msk, clr;
  logic [TW-1:0]   cnt;
  logic [CW-1:0]   cnt_fld;
  logic [PW-1:0]   pre_fld;
  logic            tmo, hit, wr_ctrl, wr_val, snap_on;

  assign wr_ctrl = we_i && addr_i == A_CTRL;
  assign wr_val  = we_i && addr_i == A_VAL;
  assign clr     = (we_i && addr_i == A_CLR) ? wdata_i[NIRQ-1:0] : '0;
  assign snap_on = per_q && snap_q;

  assign cnt_fld = up_q ? cnt[CW-1:0] : cnt[TW-1:PW];
  assign pre_fld = up_q ? cnt[TW-1:CW] : cnt[PW-1:0];

  pxt_core #(.TW(TW)) u_core (
    .clk_i, .rst_ni, .run_i(en_q), .up_i(up_q), .periodic_i(per_q),
    .limit_i(limit_q), .set_i(wr_val), .set_val_i(wdata_i),
    .cnt_o(cnt), .tmo_o(tmo)
  );

  pxt_match #(.CW(CW), .PW(PW)) u_match (
    .clk_i, .rst_ni, .run_i(en_q), .up_i(up_q), .cnt_i(cnt),
    .mhi_i(mhi_q), .mpre_i(mpre_q), .hit_o(hit)
  );

  pxt_irq #(.N(NIRQ)) u_irq (
    .clk_i, .rst_ni, .ev_i({hit, tmo}), .clr_i(clr), .mask_i(mask_q),
    .raw_o(raw), .msk_o(msk), .irq_o(irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; per_q <= 1'b0; up_q <= 1'b0; snap_q <= 1'b0;
      limit_q <= '0; mhi_q <= '0; mpre_q <= '0; mask_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q <= wdata_i[0]; per_q <= wdata_i[1];
        up_q <= wdata_i[2]; snap_q <= wdata_i[3];
      end else if (tmo && !per_q) begin
        en_q <= 1'b0;
      end
      if (we_i && addr_i == A_LIMIT) limit_q <= wdata_i;
      if (we_i && addr_i == A_MHI)   mhi_q   <= wdata_i[CW-1:0];
      if (we_i && addr_i == A_MPRE)  mpre_q  <= wdata_i[PW-1:0];
      if (we_i && addr_i == A_MASK)  mask_q  <= wdata_i[NIRQ-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snc_q <= '0; snp_q <= '0;
    end else if (tmo && snap_on) begin
      snc_q <= cnt_fld; snp_q <= pre_fld;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:  rdata_o[3:0]      = {snap_q, up_q, per_q, en_q};
      A_LIMIT: rdata_o           = limit_q;
      A_MHI:   rdata_o[CW-1:0]   = mhi_q;
      A_MPRE:  rdata_o[PW-1:0]   = mpre_q;
      A_VAL:   rdata_o           = cnt;
      A_TCNT:  rdata_o[CW-1:0]   = snap_on ? snc_q : cnt_fld;
      A_TPRE:  rdata_o[PW-1:0]   = snap_on ? snp_q : pre_fld;
      A_MASK:  rdata_o[NIRQ-1:0] = mask_q;
      A_RAW:   rdata_o[NIRQ-1:0] = raw;
      A_MSK:   rdata_o[NIRQ-1:0] = msk;
      default: rdata_o           = '0;
    endcase
  end

  a_r6_oneshot_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo && !per_q && !wr_ctrl |=> !en_q);
  a_r4_value_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_val |=> cnt == $past(wdata_i));
  a_r8_snap_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tmo |=> $stable(snc_q) && $stable(snp_q));
  a_r10_mask_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == A_MASK && !tmo && !hit |=> raw == $past(raw));
endmodule

// File: tb/pxt_timer_test.sv
module pxt_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = 4'd0;
  logic [23:0] wdata = '0;
  logic [23:0] rdata;
  logic        irq;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  string cur_tag = "R1";

  always #10 clk = ~clk;

  pxt_timer uut (.clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
                 .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  // reference model
  bit m_en, m_per, m_up, m_snap, m_eqq;
  int m_limit, m_mhi, m_mpre, m_cnt, m_snc, m_snp, m_mask, m_raw;

  function automatic int fld_c(int v, bit up);
    return up ? (v & 32'hFFFF) : ((v >> 8) & 32'hFFFF);
  endfunction
  function automatic int fld_p(int v, bit up);
    return up ? ((v >> 16) & 32'hFF) : (v & 32'hFF);
  endfunction

  function automatic int model_read(int a);
    case (a)
      0: return {28'd0, m_snap, m_up, m_per, m_en};
      1: return m_limit;
      2: return m_mhi;
      3: return m_mpre;
      4: return m_cnt;
      5: return (m_per && m_snap) ? m_snc : fld_c(m_cnt, m_up);
      6: return (m_per && m_snap) ? m_snp : fld_p(m_cnt, m_up);
      7: return m_mask;
      8: return m_raw;
      9: return m_raw & m_mask;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_per = 0; m_up = 0; m_snap = 0; m_eqq = 0;
      m_limit = 0; m_mhi = 0; m_mpre = 0; m_cnt = 0;
      m_snc = 0; m_snp = 0; m_mask = 0; m_raw = 0;
    end else begin
      int  mpt, ncnt, clrv;
      bit  eq, mev, tmo;
      mpt  = m_up ? ((m_mpre << 16) | m_mhi) : ((m_mhi << 8) | m_mpre);
      eq   = m_en && (m_cnt == mpt);
      mev  = eq && !m_eqq;
      tmo  = m_en && (m_up ? (m_cnt == m_limit) : (m_cnt == 0));
      ncnt = m_cnt;
      if (we && addr == 4) ncnt = int'(wdata);
      else if (m_en) begin
        if (tmo) begin
          if (m_per) ncnt = m_up ? 0 : m_limit;
        end else ncnt = (m_up ? m_cnt + 1 : m_cnt - 1) & 32'hFFFFFF;
      end
      if (tmo && m_per && m_snap) begin
        m_snc = fld_c(m_cnt, m_up);
        m_snp = fld_p(m_cnt, m_up);
      end
      clrv  = (we && addr == 10) ? int'(wdata[1:0]) : 0;
      m_raw = (m_raw & ~clrv) | (mev ? 2 : 0) | (tmo ? 1 : 0);
      m_eqq = eq;
      if (we && addr == 0) begin
        m_en = wdata[0]; m_per = wdata[1]; m_up = wdata[2]; m_snap = wdata[3];
      end else if (tmo && !m_per) m_en = 0;
      if (we && addr == 1) m_limit = int'(wdata);
      if (we && addr == 2) m_mhi = int'(wdata[15:0]);
      if (we && addr == 3) m_mpre = int'(wdata[7:0]);
      if (we && addr == 7) m_mask = int'(wdata[1:0]);
      m_cnt = ncnt;
    end
  end

  task automatic check(string tag, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s t=%0t addr=%0d got=%06h exp=%06h", tag, $time, addr, got, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check(cur_tag, int'(rdata), model_read(int'(addr)));
    check("R10", int'(irq), int'((m_raw & m_mask) != 0));
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired got=running exp=finished");
      summary();
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk); #1; we = 1'b1; addr = 4'(a); wdata = 24'(d);
    @(negedge clk); #1; we = 1'b0;
  endtask

  task automatic run_reads(int n, int a0, int a1, int a2, int a3);
    for (int k = 0; k < n; k++) begin
      case (k % 4)
        0: addr = 4'(a0);
        1: addr = 4'(a1);
        2: addr = 4'(a2);
        default: addr = 4'(a3);
      endcase
      @(negedge clk); #1;
    end
  endtask

  task automatic read_chk(string tag, int a, int exp);
    addr = 4'(a);
    @(negedge clk); #1;
    check(tag, int'(rdata), exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    cur_tag = "R1";
    for (int a = 0; a <= 10; a++) read_chk("R1", a, 0);
    check("R1", int'(irq), 0);

    cur_tag = "R2";
    wr(4, 24'h123456);
    read_chk("R2", 5, 16'h1234);
    read_chk("R2", 6, 8'h56);
    cur_tag = "R3";
    wr(0, 4);
    read_chk("R3", 5, 16'h3456);
    read_chk("R3", 6, 8'h12);

    // periodic down with match at 0x000110
    cur_tag = "R4";
    wr(0, 0); wr(1, 24'h000130); wr(2, 16'h0001); wr(3, 8'h10);
    wr(7, 3); wr(4, 24'h000130);
    read_chk("R4", 4, 24'h000130);
    cur_tag = "R5";
    wr(0, 4'b0011);
    run_reads(700, 4, 5, 6, 8);
    cur_tag = "R7";
    run_reads(400, 8, 9, 4, 6);

    // hold clear over events
    cur_tag = "R11";
    @(negedge clk); #1; we = 1'b1; addr = 4'd10; wdata = 24'd3;
    repeat (450) @(negedge clk);
    #1 we = 1'b0;
    read_chk("R11", 10, 0);
    run_reads(40, 8, 9, 4, 8);

    // mask lowered then raised after status set
    cur_tag = "R10";
    wr(7, 0);
    run_reads(320, 8, 9, 4, 8);
    wr(7, 2);
    run_reads(40, 9, 8, 7, 9);
    wr(10, 3);

    // snapshot in periodic down
    cur_tag = "R8";
    wr(7, 3); wr(0, 4'b1011);
    run_reads(700, 5, 6, 4, 8);

    // periodic up across counter-field wrap, snapshot on
    cur_tag = "R3";
    wr(0, 0); wr(1, 24'h010010); wr(3, 8'h01); wr(2, 16'h0005);
    wr(4, 24'h00FFF0);
    wr(0, 4'b1111);
    run_reads(120, 4, 5, 6, 8);
    cur_tag = "R9";
    wr(0, 4'b0111);
    run_reads(60, 5, 6, 4, 9);

    // one-shot down
    cur_tag = "R6";
    wr(0, 0); wr(10, 3); wr(4, 24'h000020);
    wr(0, 4'b1001);
    run_reads(60, 0, 4, 5, 6);
    read_chk("R6", 0, 4'b1000);
    read_chk("R6", 4, 0);
    read_chk("R9", 5, 0);

    // one-shot up
    wr(4, 24'h01000A);
    wr(0, 4'b0101);
    run_reads(30, 0, 4, 8, 5);
    read_chk("R6", 0, 4'b0100);
    read_chk("R6", 4, 24'h010010);
    read_chk("R9", 6, 8'h01);

    summary();
  end
endmodule